// File: doc/BRIEF.md
# Distributed Control Register Bank with OR-Merged Readback

This block holds a small set of processor-visible control registers. Each register slice is separate and decodes its own address. All slices share one simple register bus: an address, a write word, a write strobe, a read strobe and a returned read word. A slice's address is a parameter on that slice's instance. That one value serves both the write decode and the readback decode.

On a read, each slice produces a readback record: a select bit and a data word. The data word is forced to zero unless that slice is the one being read. A parameterised merger takes one record for every possible address and reduces them to a single read word and a hit flag by OR-ing them together. Addresses that have no register feed an all-zero idle record. The merger's input index therefore equals the bus address, and the registers can be placed at any sparse set of locations. There is no central address case statement.

Reads are combinational: the read word and hit flag are valid in the same cycle as the read strobe. Writes take effect at the next rising clock edge.

Top module: `regbank_top`

## Requirements
- R1: While reset is asserted and after it is released, every register holds zero. A read of any mapped address then returns 0 with the hit flag at 1.
- R2: A register loads `bus_wdata` on the rising edge where `bus_wr` is 1 and `bus_addr` equals its address. No other register changes on that edge.
- R3: A write to an address that maps no register changes no register.
- R4: With `bus_wr` at 0, no register changes, whatever `bus_addr` and `bus_wdata` hold.
- R5: While `bus_rd` is 1 and `bus_addr` matches a register, `bus_rdata` equals that register's contents and `bus_hit` is 1, in the same cycle.
- R6: While `bus_rd` is 1 and `bus_addr` maps no register, `bus_rdata` is 0 and `bus_hit` is 0.
- R7: While `bus_rd` is 0, `bus_rdata` is 0 and `bus_hit` is 0.
- R8: At most one readback select bit among all merger inputs is 1 at any time.
- R9: When a read and a write to the same register happen in the same cycle, the read returns the value the register held before that edge.
- R10: `ctrl_q` carries register i's contents in bits [32*i+31:32*i]. With the default parameters the registers sit at addresses 0x02 (i=0), 0x11 (i=1), 0x2A (i=2) and 0x3F (i=3), on a 6-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (6) | Register address |
| bus_wdata | input | 32 | Write word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Merged read word |
| bus_hit | output | 1 | A register answered the read |
| ctrl_q | output | NREG*32 (128) | Contents of all registers, register i in slice i |

## Verification
The hardest case to reach from the ports is a read and a write to the same register in one cycle. Here the merged read word must show the old contents while the new value is captured at the edge. The stimulus raises both strobes together between edges and samples the read word before the edge. A later read then confirms the new value. Sparse placement is exercised by the registers at the lowest and highest mapped addresses and by reads and writes to holes in the map. These show that idle merger inputs add nothing and that no stray register answers.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic              sel;
    logic [DATA_W-1:0] data;
  } rb_rec_t;

  localparam rb_rec_t RB_IDLE = '{sel: 1'b0, data: '0};

  // Readback gating: the word passes only when the slice is selected
  function automatic logic [DATA_W-1:0] gate_word(input logic sel, input logic [DATA_W-1:0] w);
    return sel ? w : '0;
  endfunction
endpackage

// File: rtl/csr_slot.sv
module csr_slot
  import regbank_pkg::*;
#(
  parameter int                ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output rb_rec_t           rb,
  output logic [DATA_W-1:0] q
);
  logic addr_match;
  logic wr_hit;
  logic rd_hit;

  assign addr_match = (bus_addr == MY_ADDR);
  assign wr_hit     = bus_wr && addr_match;
  assign rd_hit     = bus_rd && addr_match;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= bus_wdata;
  end

  assign rb.sel  = rd_hit;
  assign rb.data = gate_word(rd_hit, q);

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == MY_ADDR) |=> (q == $past(bus_wdata))); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == MY_ADDR) |=> $stable(q)); // R3
endmodule

// File: rtl/rb_merge.sv
module rb_merge
  import regbank_pkg::*;
#(
  parameter int N = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  rb_rec_t slot_in [N],
  output rb_rec_t merged
);
  logic [N-1:0] sels;

  always_comb begin
    merged = RB_IDLE;
    for (int i = 0; i < N; i++) begin
      sels[i]      = slot_in[i].sel;
      merged.sel   = merged.sel | slot_in[i].sel;
      merged.data  = merged.data | slot_in[i].data;
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels)); // R8
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int                     ADDR_W    = 6,
  parameter int                     NREG      = 4,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS = {6'h3F, 6'h2A, 6'h11, 6'h02}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_hit,
  output logic [NREG*DATA_W-1:0] ctrl_q
);
  localparam int SPAN = 1 << ADDR_W;

  // Index of the register living at address a, or -1 for a hole
  function automatic int slot_of(input int a);
    for (int i = 0; i < NREG; i++)
      if (int'(REG_ADDRS[i*ADDR_W +: ADDR_W]) == a) return i;
    return -1;
  endfunction

  rb_rec_t recs  [NREG];
  rb_rec_t slots [SPAN];
  rb_rec_t merged;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    csr_slot #(
      .ADDR_W (ADDR_W),
      .MY_ADDR(REG_ADDRS[i*ADDR_W +: ADDR_W])
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .rb       (recs[i]),
      .q        (ctrl_q[i*DATA_W +: DATA_W])
    );
  end

  for (genvar a = 0; a < SPAN; a++) begin : g_map
    localparam int IDX = slot_of(a);
    if (IDX >= 0) begin : g_used
      assign slots[a] = recs[IDX];
    end else begin : g_hole
      assign slots[a] = RB_IDLE;
    end
  end

  rb_merge #(.N(SPAN)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_in(slots),
    .merged (merged)
  );

  assign bus_rdata = merged.data;
  assign bus_hit   = merged.sel;

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> (bus_rdata == '0)); // R6
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> !bus_hit); // R7
endmodule

// File: tb/regbank_top_bench.sv
module regbank_top_bench;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_hit;
  logic [127:0]  ctrl_q;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  regbank_top u_regbank_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
    .ctrl_q(ctrl_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [31:0] ed, input logic eh);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2;
    chk(req, bus_rdata, ed);
    chk(req, {31'd0, bus_hit}, {31'd0, eh});
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // Vector table: write flag, address, data (write word or expected read word), expected hit
  localparam int NV = 13;
  localparam logic        V_WR  [NV] = '{1,0,0,1,1,0,0,1,0,0,1,0,0};
  localparam logic [5:0]  V_AD  [NV] = '{6'h02,6'h02,6'h11,6'h11,6'h05,6'h05,6'h11,
                                        6'h3F,6'h3F,6'h02,6'h2A,6'h2A,6'h00};
  localparam logic [31:0] V_DT  [NV] = '{32'hDEADBEEF,32'hDEADBEEF,32'h0,32'h12345678,
                                        32'hFFFFFFFF,32'h0,32'h12345678,32'hA5A5A5A5,
                                        32'hA5A5A5A5,32'hDEADBEEF,32'h0000FFFF,
                                        32'h0000FFFF,32'h0};
  localparam logic        V_HIT [NV] = '{0,1,1,0,0,0,1,0,1,1,0,1,0};

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 ctrl_q", ctrl_q[31:0], 32'h0);
    rd("R1 addr02", 6'h02, 32'h0, 1'b1);
    rd("R1 addr3F", 6'h3F, 32'h0, 1'b1);
    // R7: idle bus
    #2; chk("R7 idle rdata", bus_rdata, 32'h0);
    chk("R7 idle hit", {31'd0, bus_hit}, 32'd0);

    // Table walk: R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      if (V_WR[i]) wr(V_AD[i], V_DT[i]);
      else rd($sformatf("R5/R6 vec%0d", i), V_AD[i], V_DT[i], V_HIT[i]);
    end

    // R10: register slices on ctrl_q
    chk("R10 slot0", ctrl_q[31:0],   32'hDEADBEEF);
    chk("R10 slot1", ctrl_q[63:32],  32'h12345678);
    chk("R10 slot2", ctrl_q[95:64],  32'h0000FFFF);
    chk("R10 slot3", ctrl_q[127:96], 32'hA5A5A5A5);

    // R4: no strobe, address and data present, no change; R7 data stays zero
    @(negedge clk); bus_addr = 6'h02; bus_wdata = 32'h11111111;
    #2; chk("R7 no strobe rdata", bus_rdata, 32'h0);
    @(negedge clk);
    rd("R4 addr02 held", 6'h02, 32'hDEADBEEF, 1'b1);

    // R3: write to a hole leaves every register
    wr(6'h3E, 32'h77777777);
    chk("R3 ctrl_q", ctrl_q, {32'hA5A5A5A5, 32'h0000FFFF, 32'h12345678, 32'hDEADBEEF});

    // R9: read and write in the same cycle return the old value
    @(negedge clk); bus_addr = 6'h11; bus_wdata = 32'hCAFEF00D; bus_wr = 1'b1; bus_rd = 1'b1;
    #2; chk("R9 old value", bus_rdata, 32'h12345678);
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    rd("R9 new value", 6'h11, 32'hCAFEF00D, 1'b1);
    chk("R2 neighbour unchanged", ctrl_q[95:64], 32'h0000FFFF);

    // R1: reset mid-run clears all
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 after reset", ctrl_q[127:96] | ctrl_q[95:64] | ctrl_q[63:32] | ctrl_q[31:0], 32'h0);
    rd("R1 addr2A", 6'h2A, 32'h0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule